// File: doc/BRIEF.md
# Transactional Execution State Controller

This block keeps the hardware transactional state of one thread. Decoded transactional operations arrive one per cycle: begin, end, unconditional abort, conditional abort, suspend, resume and check. Each comes with its program counter, an 8-bit abort code and compare operands. Failure events reported by the memory side arrive on a separate input. The block holds a flat nesting counter, a handler address register, a failing-address register and a status register that records the failure cause. Every operation gets a one-bit condition result one cycle later. When a failure has to be handled, the block produces a one-cycle redirect request that carries the handler address.

There are three states: non-transactional, transactional and suspended. Under flat nesting, any failure rolls the thread back to the outermost begin. The handler address is that begin's program counter plus 4. In the suspended state a failure is recorded at once, but the redirect waits until the transaction is resumed. A check operation lets software poll for such a pending failure without changing any state.

Top module: `txn_state_ctrl`

## Requirements
- R1: After reset, state_o is non-transactional (0), nest_o is 0, status_o and fail_addr_o are 0, and neither rsp_valid_o nor redirect_valid_o is asserted.
- R2: A begin (op 0) in the non-transactional state moves to transactional (1) with nest 1 and latches pc+4 as the handler address. A begin in the transactional state only increments nest. Both return flag 1.
- R3: An end (op 1) in the transactional state decrements nest, and at nest 1 commits to non-transactional with nest 0 and no redirect. An end in the non-transactional state returns flag 1 (extraneous) and changes nothing. An end in the suspended state returns flag 0 and changes nothing. Nest is 0 whenever the state is non-transactional.
- R4: A failure in the transactional state gives, one cycle later, a single-cycle redirect_valid_o with redirect_pc_o equal to the latched handler address. At that point state_o is 0, nest_o is 0 and fail_addr_o holds the failing address: pc_i for operations, fail_pc_i for external events.
- R5: status_o is {persistent[11], cause[10:8], code[7:0]}. Causes: 1 conflict, 2 explicit abort, 3 footprint overflow, 4 nesting overflow, 5 non-write-back access, 6 disallowed instruction. Causes 3 to 6 set the persistent bit. Code is non-zero only for aborts. status_o changes only when a failure is recorded.
- R6: An unconditional abort (op 2) in an active transaction fails it with cause 2, records abort_code_i and returns flag 1. In the non-transactional state it returns flag 0 and has no effect.
- R7: A conditional abort (op 3) fails only when its comparison is true, and returns flag 1 exactly then. cmp_sel_i selects the comparison of cmp_a_i against the second operand: 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than. The second operand is cmp_b_i, or imm_i sign-extended when use_imm_i is 1.
- R8: A begin at nest 31 does not nest further. It raises a nesting-overflow failure (cause 4, persistent) and returns flag 0.
- R9: A suspend (op 4) moves transactional to suspended (2), and a resume (op 5) moves suspended to transactional. Both keep nest and return flag 1. A begin in the suspended state returns flag 0 and changes nothing.
- R10: A failure in the suspended state updates status_o and fail_addr_o immediately, with no redirect. Further failures are then ignored. The next resume produces the redirect and returns to non-transactional with nest 0.
- R11: A check (op 6) returns flag 1 exactly when the suspended transaction has a recorded failure, and changes no state.
- R12: An external failure has priority over an operation in the same cycle; that operation returns flag 0 and takes no effect. External failures in the non-transactional state are ignored.
- R13: Every operation gets rsp_valid_o exactly one cycle after op_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 begin, 1 end, 2 abort, 3 conditional abort, 4 suspend, 5 resume, 6 check) |
| pc_i | input | PC_W | Program counter of the operation |
| abort_code_i | input | 8 | Software code for aborts |
| cmp_sel_i | input | 2 | Conditional abort comparison select |
| cmp_a_i | input | DATA_W | First compare operand |
| cmp_b_i | input | DATA_W | Second compare operand (register form) |
| use_imm_i | input | 1 | Use the immediate as the second operand |
| imm_i | input | IMM_W | Immediate second operand, sign-extended |
| fail_valid_i | input | 1 | Failure event from the memory side |
| fail_cause_i | input | 3 | Cause code of the failure event |
| fail_pc_i | input | PC_W | Address of the failing access |
| state_o | output | 2 | 0 non-transactional, 1 transactional, 2 suspended |
| nest_o | output | NEST_W | Current nesting level |
| rsp_valid_o | output | 1 | Condition result valid |
| rsp_flag_o | output | 1 | Condition result of the previous operation |
| redirect_valid_o | output | 1 | Redirect to handler request |
| redirect_pc_o | output | PC_W | Handler address |
| status_o | output | 12 | Failure status |
| fail_addr_o | output | PC_W | Failing address of the last recorded failure |

## Verification
The assertions check, on every cycle, several invariants. Nest is zero whenever the state is idle. A redirect never follows a cycle spent non-transactional. Only a suspend operation enters the suspended state. A pending failure exists only while suspended. Every operation gets a response in the next cycle. The status never moves without a recorded failure. Other properties depend on ordered stimulus and are shown only by the bench's scenarios and its cycle-accurate reference model: the deferral of a redirect from a suspended failure until resume, the handler address surviving deep nesting, overflow at level 31, and the compare encodings of the conditional abort.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int CODE_W   = 8;
  localparam int CAUSE_W  = 3;
  localparam int STATUS_W = 1 + CAUSE_W + CODE_W;

  typedef enum logic [2:0] {
    OP_BEGIN   = 3'd0,
    OP_END     = 3'd1,
    OP_ABORT   = 3'd2,
    OP_ABORT_C = 3'd3,
    OP_SUSP    = 3'd4,
    OP_RESUME  = 3'd5,
    OP_CHECK   = 3'd6
  } txn_op_e;

  typedef enum logic [1:0] {
    ST_NT = 2'd0,
    ST_TX = 2'd1,
    ST_SP = 2'd2
  } txn_state_e;

  localparam logic [CAUSE_W-1:0] CS_CONFLICT  = 3'd1;
  localparam logic [CAUSE_W-1:0] CS_ABORT     = 3'd2;
  localparam logic [CAUSE_W-1:0] CS_FOOTPRINT = 3'd3;
  localparam logic [CAUSE_W-1:0] CS_NEST      = 3'd4;
  localparam logic [CAUSE_W-1:0] CS_NONWB     = 3'd5;
  localparam logic [CAUSE_W-1:0] CS_DISALLOW  = 3'd6;

  function automatic logic cause_persistent(logic [CAUSE_W-1:0] c);
    return (c == CS_FOOTPRINT) || (c == CS_NEST) || (c == CS_NONWB) || (c == CS_DISALLOW);
  endfunction
endpackage

// File: rtl/txn_abort_eval.sv
module txn_abort_eval #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] rhs;

  assign imm_ext = DATA_W'($signed(imm_i));
  assign rhs     = use_imm_i ? imm_ext : b_i;

  always_comb begin
    unique case (sel_i)
      2'd0:    hit_o = (a_i == rhs);
      2'd1:    hit_o = (a_i != rhs);
      2'd2:    hit_o = ($signed(a_i) < $signed(rhs));
      default: hit_o = (a_i < rhs);
    endcase
  end
endmodule

// File: rtl/txn_fail_rec.sv
module txn_fail_rec
  import txn_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rec_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [PC_W-1:0]     addr_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [PC_W-1:0]     fail_addr_o
);
  logic [STATUS_W-1:0] status_q;
  logic [PC_W-1:0]     addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      addr_q   <= '0;
    end else if (rec_i) begin
      status_q <= {cause_persistent(cause_i), cause_i, code_i};
      addr_q   <= addr_i;
    end
  end

  assign status_o    = status_q;
  assign fail_addr_o = addr_q;

  assert_status_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_i |=> $stable(status_q));
endmodule

// File: rtl/txn_core.sv
module txn_core
  import txn_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int NEST_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [2:0]         op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [CODE_W-1:0]  abort_code_i,
  input  logic               cond_hit_i,
  input  logic               fail_valid_i,
  input  logic [CAUSE_W-1:0] fail_cause_i,
  input  logic [PC_W-1:0]    fail_pc_i,
  output logic               rec_o,
  output logic [CAUSE_W-1:0] rec_cause_o,
  output logic [CODE_W-1:0]  rec_code_o,
  output logic [PC_W-1:0]    rec_addr_o,
  output txn_state_e         state_o,
  output logic [NEST_W-1:0]  nest_o,
  output logic               rsp_valid_o,
  output logic               rsp_flag_o,
  output logic               redirect_valid_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  localparam logic [NEST_W-1:0] NEST_MAX = '1;
  localparam logic [NEST_W-1:0] NEST_ONE = NEST_W'(1);

  txn_state_e        state_q, state_d;
  logic [NEST_W-1:0] nest_q, nest_d;
  logic [PC_W-1:0]   hdlr_q, hdlr_d;
  logic              failed_q, failed_d;
  logic              redir_q, redir_d;
  logic              rsp_q, flag_q, flag_d;
  logic              in_tx, in_sp, can_fail;

  assign in_tx    = (state_q == ST_TX);
  assign in_sp    = (state_q == ST_SP);
  assign can_fail = in_tx || (in_sp && !failed_q);

  always_comb begin
    state_d     = state_q;
    nest_d      = nest_q;
    hdlr_d      = hdlr_q;
    failed_d    = failed_q;
    redir_d     = 1'b0;
    flag_d      = 1'b0;
    rec_o       = 1'b0;
    rec_cause_o = '0;
    rec_code_o  = '0;
    rec_addr_o  = pc_i;

    if (fail_valid_i && can_fail) begin
      // external event wins over any same-cycle operation
      rec_o       = 1'b1;
      rec_cause_o = fail_cause_i;
      rec_addr_o  = fail_pc_i;
    end else if (op_valid_i) begin
      unique case (txn_op_e'(op_i))
        OP_BEGIN: begin
          if (state_q == ST_NT) begin
            state_d = ST_TX;
            nest_d  = NEST_ONE;
            hdlr_d  = pc_i + PC_W'(4);
            flag_d  = 1'b1;
          end else if (in_tx) begin
            if (nest_q == NEST_MAX) begin
              rec_o       = 1'b1;
              rec_cause_o = CS_NEST;
            end else begin
              nest_d = nest_q + NEST_ONE;
              flag_d = 1'b1;
            end
          end
        end
        OP_END: begin
          if (state_q == ST_NT) begin
            flag_d = 1'b1;
          end else if (in_tx) begin
            nest_d = nest_q - NEST_ONE;
            if (nest_q == NEST_ONE) state_d = ST_NT;
          end
        end
        OP_ABORT, OP_ABORT_C: begin
          if (can_fail && (op_i == OP_ABORT || cond_hit_i)) begin
            rec_o       = 1'b1;
            rec_cause_o = CS_ABORT;
            rec_code_o  = abort_code_i;
            flag_d      = 1'b1;
          end
        end
        OP_SUSP: begin
          if (in_tx) begin
            state_d = ST_SP;
            flag_d  = 1'b1;
          end
        end
        OP_RESUME: begin
          if (in_sp) begin
            flag_d = 1'b1;
            if (failed_q) begin
              state_d  = ST_NT;
              nest_d   = '0;
              failed_d = 1'b0;
              redir_d  = 1'b1;
            end else begin
              state_d = ST_TX;
            end
          end
        end
        OP_CHECK: flag_d = failed_q;
        default: ;
      endcase
    end

    if (rec_o) begin
      if (in_tx) begin
        state_d = ST_NT;
        nest_d  = '0;
        redir_d = 1'b1;
      end else begin
        failed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_NT;
      nest_q   <= '0;
      hdlr_q   <= '0;
      failed_q <= 1'b0;
      redir_q  <= 1'b0;
      rsp_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      nest_q   <= nest_d;
      hdlr_q   <= hdlr_d;
      failed_q <= failed_d;
      redir_q  <= redir_d;
      rsp_q    <= op_valid_i;
      flag_q   <= flag_d;
    end
  end

  assign state_o          = state_q;
  assign nest_o           = nest_q;
  assign rsp_valid_o      = rsp_q;
  assign rsp_flag_o       = flag_q;
  assign redirect_valid_o = redir_q;
  assign redirect_pc_o    = hdlr_q;

  assert_idle_nest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NT) |-> (nest_q == '0));
  assert_no_redirect_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NT) |=> !redir_q);
  assert_susp_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SP && !(op_valid_i && op_i == OP_SUSP)) |=> (state_q != ST_SP));
  assert_pending_only_susp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_q |-> (state_q == ST_SP));
  assert_rsp_follows_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> rsp_q);
endmodule

// File: rtl/txn_state_ctrl.sv
module txn_state_ctrl
  import txn_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int NEST_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [2:0]          op_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic [CODE_W-1:0]   abort_code_i,
  input  logic [1:0]          cmp_sel_i,
  input  logic [DATA_W-1:0]   cmp_a_i,
  input  logic [DATA_W-1:0]   cmp_b_i,
  input  logic                use_imm_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic                fail_valid_i,
  input  logic [CAUSE_W-1:0]  fail_cause_i,
  input  logic [PC_W-1:0]     fail_pc_i,
  output logic [1:0]          state_o,
  output logic [NEST_W-1:0]   nest_o,
  output logic                rsp_valid_o,
  output logic                rsp_flag_o,
  output logic                redirect_valid_o,
  output logic [PC_W-1:0]     redirect_pc_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [PC_W-1:0]     fail_addr_o
);
  logic               cond_hit;
  logic               rec;
  logic [CAUSE_W-1:0] rec_cause;
  logic [CODE_W-1:0]  rec_code;
  logic [PC_W-1:0]    rec_addr;
  txn_state_e         state;

  txn_abort_eval #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_eval (
    .sel_i     (cmp_sel_i),
    .a_i       (cmp_a_i),
    .b_i       (cmp_b_i),
    .use_imm_i (use_imm_i),
    .imm_i     (imm_i),
    .hit_o     (cond_hit)
  );

  txn_core #(.PC_W(PC_W), .NEST_W(NEST_W)) u_core (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .op_valid_i       (op_valid_i),
    .op_i             (op_i),
    .pc_i             (pc_i),
    .abort_code_i     (abort_code_i),
    .cond_hit_i       (cond_hit),
    .fail_valid_i     (fail_valid_i),
    .fail_cause_i     (fail_cause_i),
    .fail_pc_i        (fail_pc_i),
    .rec_o            (rec),
    .rec_cause_o      (rec_cause),
    .rec_code_o       (rec_code),
    .rec_addr_o       (rec_addr),
    .state_o          (state),
    .nest_o           (nest_o),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_flag_o       (rsp_flag_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
  );

  txn_fail_rec #(.PC_W(PC_W)) u_rec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rec_i       (rec),
    .cause_i     (rec_cause),
    .code_i      (rec_code),
    .addr_i      (rec_addr),
    .status_o    (status_o),
    .fail_addr_o (fail_addr_o)
  );

  assign state_o = state;
endmodule

// File: tb/txn_state_ctrl_bench.sv
`timescale 1ns/1ps
module txn_state_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0;
  logic [2:0]  op = 0;
  logic [31:0] pc = 0;
  logic [7:0]  code = 0;
  logic [1:0]  sel = 0;
  logic [31:0] ca = 0, cb = 0;
  logic        use_imm = 0;
  logic [15:0] imm = 0;
  logic        fv = 0;
  logic [2:0]  fc = 0;
  logic [31:0] fpc = 0;

  logic [1:0]  state;
  logic [4:0]  nest;
  logic        rsp_v, rsp_f, red_v;
  logic [31:0] red_pc, faddr;
  logic [11:0] status;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  txn_state_ctrl u_txn_state_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .pc_i(pc),
    .abort_code_i(code), .cmp_sel_i(sel), .cmp_a_i(ca), .cmp_b_i(cb),
    .use_imm_i(use_imm), .imm_i(imm), .fail_valid_i(fv), .fail_cause_i(fc),
    .fail_pc_i(fpc), .state_o(state), .nest_o(nest), .rsp_valid_o(rsp_v),
    .rsp_flag_o(rsp_f), .redirect_valid_o(red_v), .redirect_pc_o(red_pc),
    .status_o(status), .fail_addr_o(faddr)
  );

  // reference model
  int          m_state, m_nest;
  logic [31:0] m_hdlr, m_faddr;
  logic        m_failed, m_rv, m_rf, m_redir;
  logic [11:0] m_status;

  function automatic bit ref_hit();
    logic [31:0] r;
    r = use_imm ? {{16{imm[15]}}, imm} : cb;
    case (sel)
      0: return ca == r;
      1: return ca != r;
      2: return $signed(ca) < $signed(r);
      default: return ca < r;
    endcase
  endfunction

  function automatic logic [11:0] mk_status(int c, logic [7:0] k);
    return {(c >= 3 && c <= 6) ? 1'b1 : 1'b0, 3'(c), k};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_nest = 0; m_hdlr = 0; m_faddr = 0; m_failed = 0;
      m_rv = 0; m_rf = 0; m_redir = 0; m_status = 0;
    end else begin
      bit fail; int fcause; logic [7:0] fcode; logic [31:0] fad; bit active;
      fail = 0; fcause = 0; fcode = 0; fad = pc;
      active = (m_state == 1) || (m_state == 2 && !m_failed);
      m_redir = 0; m_rf = 0; m_rv = op_valid;
      if (fv && active) begin
        fail = 1; fcause = fc; fad = fpc;
      end else if (op_valid) begin
        case (op)
          0: if (m_state == 0) begin m_state = 1; m_nest = 1; m_hdlr = pc + 4; m_rf = 1; end
             else if (m_state == 1) begin
               if (m_nest == 31) begin fail = 1; fcause = 4; end
               else begin m_nest++; m_rf = 1; end
             end
          1: if (m_state == 0) m_rf = 1;
             else if (m_state == 1) begin m_nest--; if (m_nest == 0) m_state = 0; end
          2, 3: if (active && (op == 2 || ref_hit())) begin fail = 1; fcause = 2; fcode = code; m_rf = 1; end
          4: if (m_state == 1) begin m_state = 2; m_rf = 1; end
          5: if (m_state == 2) begin
               m_rf = 1;
               if (m_failed) begin m_state = 0; m_nest = 0; m_failed = 0; m_redir = 1; end
               else m_state = 1;
             end
          6: m_rf = m_failed;
          default: ;
        endcase
      end
      if (fail) begin
        m_status = mk_status(fcause, fcode); m_faddr = fad;
        if (m_state == 1) begin m_state = 0; m_nest = 0; m_redir = 1; end
        else m_failed = 1;
      end
    end
  end

  always @(negedge clk) begin
    bit bad;
    cyc++;
    bad = 0;
    checks++;
    if (state !== 2'(m_state) || nest !== 5'(m_nest)) begin
      bad = 1; $display("FAIL %s state/nest act=%0d/%0d exp=%0d/%0d", cur_req, state, nest, m_state, m_nest);
    end
    if (rsp_v !== m_rv || (m_rv && rsp_f !== m_rf)) begin
      bad = 1; $display("FAIL %s rsp act=%b/%b exp=%b/%b", cur_req, rsp_v, rsp_f, m_rv, m_rf);
    end
    if (red_v !== m_redir || (m_redir && red_pc !== m_hdlr)) begin
      bad = 1; $display("FAIL %s redirect act=%b/%h exp=%b/%h", cur_req, red_v, red_pc, m_redir, m_hdlr);
    end
    if (status !== m_status || faddr !== m_faddr) begin
      bad = 1; $display("FAIL %s status/addr act=%h/%h exp=%h/%h", cur_req, status, faddr, m_status, m_faddr);
    end
    if (bad) errors++;
    if (cyc > 100000) begin
      errors++; $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(int o, logic [31:0] p, logic [7:0] k = 0);
    op_valid = 1; op = 3'(o); pc = p; code = k;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic ext_fail(int c, logic [31:0] p);
    fv = 1; fc = 3'(c); fpc = p;
    @(negedge clk);
    fv = 0;
  endtask

  task automatic set_cmp(int s, logic [31:0] a, logic [31:0] b, bit ui, logic [15:0] im);
    sel = 2'(s); ca = a; cb = b; use_imm = ui; imm = im;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 state", {30'd0, state}, 0); chk("R1 status", {20'd0, status}, 0);
    chk("R1 rsp", {31'd0, rsp_v}, 0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R3"; do_op(1, 32'h10);
    chk("R3 extraneous end", {31'd0, rsp_f}, 1);
    cur_req = "R6"; do_op(2, 32'h14, 8'h77);
    chk("R6 abort idle no effect", {20'd0, status}, 0);
    cur_req = "R12"; ext_fail(1, 32'h18);
    chk("R12 idle fail ignored", {20'd0, status}, 0);

    cur_req = "R2"; do_op(0, 32'h100);
    chk("R2 begin flag", {31'd0, rsp_f}, 1); chk("R2 state", {30'd0, state}, 1);
    do_op(0, 32'h200); do_op(0, 32'h300);
    chk("R2 nest", {27'd0, nest}, 3);
    cur_req = "R3"; do_op(1, 32'h304); do_op(1, 32'h308);
    chk("R3 nest down", {27'd0, nest}, 1);
    do_op(1, 32'h30c);
    chk("R3 commit", {30'd0, state}, 0); chk("R3 no redirect", {31'd0, red_v}, 0);

    cur_req = "R4"; do_op(0, 32'h400); do_op(0, 32'h500);
    ext_fail(1, 32'hABC0);
    chk("R4 redirect", {31'd0, red_v}, 1); chk("R4 handler", red_pc, 32'h404);
    chk("R4 fail addr", faddr, 32'hABC0); chk("R5 conflict status", {20'd0, status}, 32'h100);
    @(negedge clk);
    chk("R4 single pulse", {31'd0, red_v}, 0);

    cur_req = "R6"; do_op(0, 32'h600); do_op(2, 32'h608, 8'h5A);
    chk("R6 abort status", {20'd0, status}, 32'h25A); chk("R6 abort flag", {31'd0, rsp_f}, 1);

    cur_req = "R7";
    do_op(0, 32'h700); set_cmp(0, 5, 6, 0, 0); do_op(3, 32'h704, 8'h11);
    chk("R7 eq false", {30'd0, state}, 1);
    set_cmp(2, 32'hFFFF_FFFB, 3, 0, 0); do_op(3, 32'h708, 8'h12);
    chk("R7 slt true", {31'd0, red_v}, 1);
    do_op(0, 32'h710); set_cmp(3, 32'hFFFF_FFFB, 3, 0, 0); do_op(3, 32'h714);
    chk("R7 ult false", {31'd0, rsp_f}, 0);
    set_cmp(0, 32'hFFFF_FFFF, 0, 1, 16'hFFFF); do_op(3, 32'h718, 8'h13);
    chk("R7 imm eq true", {20'd0, status}, 32'h213);
    do_op(0, 32'h720); set_cmp(1, 9, 9, 0, 0); do_op(3, 32'h724);
    chk("R7 ne false", {30'd0, state}, 1);
    do_op(1, 32'h728);

    cur_req = "R8"; do_op(0, 32'h800);
    for (int i = 0; i < 30; i++) do_op(0, 32'h900 + 32'(i));
    chk("R8 at max", {27'd0, nest}, 31);
    do_op(0, 32'hA00);
    chk("R8 overflow status", {20'd0, status}, 32'hC00); chk("R8 redirect", red_pc, 32'h804);
    chk("R8 flag", {31'd0, rsp_f}, 0);

    cur_req = "R9"; do_op(0, 32'hB00); do_op(0, 32'hB10); do_op(4, 32'hB20);
    chk("R9 suspended", {30'd0, state}, 2);
    do_op(0, 32'hB30);
    chk("R9 begin refused", {31'd0, rsp_f}, 0); chk("R9 nest kept", {27'd0, nest}, 2);
    cur_req = "R11"; do_op(6, 32'hB34);
    chk("R11 check clean", {31'd0, rsp_f}, 0);
    cur_req = "R9"; do_op(5, 32'hB40);
    chk("R9 resumed", {30'd0, state}, 1);

    cur_req = "R10"; do_op(4, 32'hB50);
    ext_fail(3, 32'hCC00);
    chk("R10 no redirect", {31'd0, red_v}, 0); chk("R10 status now", {20'd0, status}, 32'hB00);
    ext_fail(1, 32'hDD00);
    chk("R10 second ignored", faddr, 32'hCC00);
    cur_req = "R11"; do_op(6, 32'hB60);
    chk("R11 check failed", {31'd0, rsp_f}, 1); chk("R11 state kept", {30'd0, state}, 2);
    cur_req = "R10"; do_op(5, 32'hB70);
    chk("R10 resume redirect", {31'd0, red_v}, 1); chk("R10 to idle", {30'd0, state}, 0);

    cur_req = "R12"; do_op(0, 32'hC00);
    fv = 1; fc = 6; fpc = 32'hEE00; do_op(1, 32'hC04); fv = 0;
    chk("R12 fail wins", {20'd0, status}, 32'hE00); chk("R13 rsp", {31'd0, rsp_v}, 1);
    chk("R12 op flag", {31'd0, rsp_f}, 0);

    cur_req = "R13";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      op_valid = (r < 70); op = 3'($urandom_range(0, 6));
      if (r < 25) op = 0;
      pc = $urandom; code = 8'($urandom);
      set_cmp($urandom_range(0, 3), 32'($urandom_range(0, 3)), 32'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 16'($urandom_range(0, 3)));
      fv = ($urandom_range(0, 99) < 6); fc = 3'($urandom_range(1, 6)); fpc = $urandom;
      @(negedge clk);
    end
    op_valid = 0; fv = 0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule